// File: doc/BRIEF.md
# DRAM Mode Register Decoder

This block sits on the device side of a DDR SDRAM command interface and handles mode-register programming. Each clock it sees one decoded command strobe (register write, read, any other command, self-refresh entry or exit), the two bank-select bits and a 12-bit address word. It keeps the base mode register and the extended mode register, and it follows the state of the on-die delay-locked loop (DLL).

The DLL is on when the extended register enables it and the device is outside self refresh. Every time the DLL turns on, a lock counter restarts. A short settling window also opens, and non-read commands must wait for it to close. Three error outputs report problems. `errReserved` covers encodings the device does not support. `errTiming` covers reads issued before lock and non-read commands issued inside a settling window. `errSequence` covers ordering and bank-state violations.

A bench or a larger controller model uses it to police a command stream. It reads the register contents and the lock flag straight from the outputs.

Top module: `dram_mode_decoder`

## Requirements
- R1: A register write with bank bits 01 writes the extended register, and bank bits 00 write the base register. Bank bits 10 or 11 raise errReserved and leave both registers unchanged.
- R2: A base write whose bits 11:7 are 00000 (normal operation) or 00010 (DLL reset) is accepted. All 12 address bits then appear on baseReg after the write edge.
- R3: A base write with any other value in bits 11:7 raises errReserved and leaves baseReg unchanged.
- R4: In the extended register, bit 0 = 0 enables the DLL and 1 disables it. Bit 2 is stored as the optional output-isolation enable. A write with bit 1 = 1 or any of bits 11:3 set raises errReserved and leaves extReg unchanged.
- R5: An extended write while banksIdle is low raises errSequence and is not stored.
- R6: Reset clears both registers. The DLL is then enabled and dllLocked is low, and dllLocked rises after 200 clock edges.
- R7: Once the DLL turns on at edge E, a read at edge E+199 or earlier raises errTiming and a read at E+200 does not. A read while the DLL is off always raises errTiming.
- R8: An extended write that turns the DLL on from off at edge E makes a non-read command at E+1 raise errTiming. The same command at E+2 does not.
- R9: Self-refresh entry turns the DLL off and drops dllLocked. Exit at edge X turns it back on (if extended bit 0 is 0) and restarts the 200-edge lock count. A non-read command at X+9 raises errTiming and one at X+10 does not.
- R10: After a DLL-reset base write, the next command must be a normal-operation base write. Any other command raises errSequence.
- R11: Error outputs are registered pulses. Each is high only in the cycle after the offending command edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset (stands in for power loss) |
| cmdMrs | input | 1 | Mode register write strobe |
| cmdRead | input | 1 | Read command strobe |
| cmdOther | input | 1 | Any other non-read command strobe |
| cmdSrEnter | input | 1 | Self-refresh entry strobe |
| cmdSrExit | input | 1 | Self-refresh exit strobe |
| bankAddr | input | 2 | Bank select bits |
| addr | input | 12 | Address bus |
| banksIdle | input | 1 | High when every bank is idle |
| dllLocked | output | 1 | DLL enabled and lock window elapsed |
| errReserved | output | 1 | Reserved encoding pulse |
| errTiming | output | 1 | Lock or settling window violation pulse |
| errSequence | output | 1 | Ordering or bank-state violation pulse |
| baseReg | output | 12 | Base mode register contents |
| extReg | output | 12 | Extended mode register contents |

## Verification
An off-by-one in the lock or settling counter shows up at the first read or non-read command placed exactly on the window boundary. The error pulse then appears or goes missing one cycle after that edge. A wrong self-refresh or DLL-enable state shows at once on dllLocked, and shows again on errTiming for the next read. A stale DLL-reset pending flag surfaces as a wrong errSequence on the very next command. A faulty register write shows on baseReg or extReg in the cycle after the write edge.

// File: rtl/dram_mode_pkg.sv
package dram_mode_pkg;
  // write strobes handed from control to the register datapath
  typedef struct packed {
    logic wrBase;
    logic wrExt;
  } regStrobe_t;
endpackage

// File: rtl/dram_mode_regs.sv
module dram_mode_regs
  import dram_mode_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] baseReg,
  output logic [ADDR_W-1:0] extReg
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg <= '0;
      extReg  <= '0;
    end else begin
      if (strobe.wrBase) baseReg <= addr;
      if (strobe.wrExt)  extReg  <= addr;
    end
  end

  // R4
  ext_fields_chk: assert property (@(posedge clk) disable iff (!rstN)
    (extReg[ADDR_W-1:3] == '0) && !extReg[1]);

  // R2
  base_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (baseReg[ADDR_W-1:7] == '0) || (baseReg[ADDR_W-1:7] == (ADDR_W-7)'(2)));

  // R1
  ext_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrExt |=> $stable(extReg));

endmodule

// File: rtl/dram_mode_ctrl.sv
module dram_mode_ctrl
  import dram_mode_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int LOCK_CYC = 200,
  parameter int MRD_CYC  = 2,
  parameter int XSNR_CYC = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdMrs,
  input  logic              cmdRead,
  input  logic              cmdOther,
  input  logic              cmdSrEnter,
  input  logic              cmdSrExit,
  input  logic [1:0]        bankAddr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              banksIdle,
  input  logic              extDllOff,
  output regStrobe_t        strobe,
  output logic              dllLocked,
  output logic              errReserved,
  output logic              errTiming,
  output logic              errSequence
);

  localparam int MAX_CYC = (LOCK_CYC > XSNR_CYC) ? LOCK_CYC : XSNR_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int MODE_W  = ADDR_W - 7;

  logic             inSr, pendNormal;
  logic [CNT_W-1:0] lockCnt, gapCnt, gapNeed;

  logic selBase, selExt, badBank, baseNormal, baseDllRst, baseOk, extOk;
  logic anyCmd, nonRead, reservedHit, seqHit, timingHit;
  logic nextInSr, nextExtOff, curEn, nextEn, enEvent;

  always_comb begin
    selBase    = cmdMrs && (bankAddr == 2'b00);
    selExt     = cmdMrs && (bankAddr == 2'b01);
    badBank    = cmdMrs && bankAddr[1];
    baseNormal = (addr[ADDR_W-1:7] == '0);
    baseDllRst = (addr[ADDR_W-1:7] == MODE_W'(2));
    baseOk     = baseNormal || baseDllRst;
    extOk      = !addr[1] && (addr[ADDR_W-1:3] == '0);

    strobe.wrBase = selBase && baseOk;
    strobe.wrExt  = selExt && extOk && banksIdle;

    anyCmd  = cmdMrs || cmdRead || cmdOther || cmdSrEnter || cmdSrExit;
    nonRead = anyCmd && !cmdRead;

    curEn     = !inSr && !extDllOff;
    dllLocked = curEn && (lockCnt >= CNT_W'(LOCK_CYC));

    reservedHit = badBank || (selBase && !baseOk) || (selExt && !extOk);
    seqHit      = (pendNormal && anyCmd && !(selBase && baseNormal))
               || (selExt && extOk && !banksIdle);
    timingHit   = (cmdRead && !dllLocked) || (nonRead && (gapCnt < gapNeed));

    nextInSr   = cmdSrExit ? 1'b0 : (cmdSrEnter ? 1'b1 : inSr);
    nextExtOff = strobe.wrExt ? addr[0] : extDllOff;
    nextEn     = !nextInSr && !nextExtOff;
    enEvent    = nextEn && !curEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSr        <= 1'b0;
      pendNormal  <= 1'b0;
      lockCnt     <= '0;
      gapCnt      <= CNT_W'(MAX_CYC);
      gapNeed     <= '0;
      errReserved <= 1'b0;
      errTiming   <= 1'b0;
      errSequence <= 1'b0;
    end else begin
      inSr        <= nextInSr;
      errReserved <= reservedHit;
      errTiming   <= timingHit;
      errSequence <= seqHit;

      if (strobe.wrBase && baseDllRst) pendNormal <= 1'b1;
      else if (anyCmd)                 pendNormal <= 1'b0;

      if (!nextEn)                                lockCnt <= '0;
      else if (enEvent)                           lockCnt <= CNT_W'(1);
      else if (lockCnt < CNT_W'(LOCK_CYC))        lockCnt <= lockCnt + 1'b1;

      if (enEvent) begin
        gapCnt  <= CNT_W'(1);
        gapNeed <= cmdSrExit ? CNT_W'(XSNR_CYC) : CNT_W'(MRD_CYC);
      end else if (gapCnt < CNT_W'(MAX_CYC)) begin
        gapCnt <= gapCnt + 1'b1;
      end
    end
  end

  // R7
  early_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRead && !dllLocked) |=> errTiming);

  // R9
  sr_enter_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdSrEnter |=> !dllLocked);

  // R9
  sr_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdSrExit |=> !dllLocked);

  // R11
  reserved_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdMrs |=> !errReserved);

endmodule

// File: rtl/dram_mode_decoder.sv
module dram_mode_decoder
  import dram_mode_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int LOCK_CYC = 200,
  parameter int MRD_CYC  = 2,
  parameter int XSNR_CYC = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdMrs,
  input  logic              cmdRead,
  input  logic              cmdOther,
  input  logic              cmdSrEnter,
  input  logic              cmdSrExit,
  input  logic [1:0]        bankAddr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              banksIdle,
  output logic              dllLocked,
  output logic              errReserved,
  output logic              errTiming,
  output logic              errSequence,
  output logic [ADDR_W-1:0] baseReg,
  output logic [ADDR_W-1:0] extReg
);

  regStrobe_t strobe;

  dram_mode_ctrl #(
    .ADDR_W(ADDR_W), .LOCK_CYC(LOCK_CYC), .MRD_CYC(MRD_CYC), .XSNR_CYC(XSNR_CYC)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .cmdMrs(cmdMrs), .cmdRead(cmdRead), .cmdOther(cmdOther),
    .cmdSrEnter(cmdSrEnter), .cmdSrExit(cmdSrExit),
    .bankAddr(bankAddr), .addr(addr), .banksIdle(banksIdle),
    .extDllOff(extReg[0]), .strobe(strobe),
    .dllLocked(dllLocked), .errReserved(errReserved),
    .errTiming(errTiming), .errSequence(errSequence)
  );

  dram_mode_regs #(.ADDR_W(ADDR_W)) uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr),
    .baseReg(baseReg), .extReg(extReg)
  );

endmodule

// File: tb/tb_dram_mode_decoder.sv
module tb_dram_mode_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdMrs = 0, cmdRead = 0, cmdOther = 0, cmdSrEnter = 0, cmdSrExit = 0;
  logic [1:0]  bankAddr = '0;
  logic [11:0] addr = '0;
  logic        banksIdle = 1'b1;
  logic        dllLocked, errReserved, errTiming, errSequence;
  logic [11:0] baseReg, extReg;

  int total = 0;
  int bad   = 0;
  logic [11:0] expBase, expExt;

  always #2 clk = ~clk;

  dram_mode_decoder dut (
    .clk(clk), .rstN(rstN), .cmdMrs(cmdMrs), .cmdRead(cmdRead), .cmdOther(cmdOther),
    .cmdSrEnter(cmdSrEnter), .cmdSrExit(cmdSrExit), .bankAddr(bankAddr), .addr(addr),
    .banksIdle(banksIdle), .dllLocked(dllLocked), .errReserved(errReserved),
    .errTiming(errTiming), .errSequence(errSequence), .baseReg(baseReg), .extReg(extReg)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // kinds: 0 register write, 1 read, 2 other, 3 self-refresh entry, 4 self-refresh exit
  task automatic issue(input int kind, input logic [1:0] ba, input logic [11:0] a);
    cmdMrs     = (kind == 0);
    cmdRead    = (kind == 1);
    cmdOther   = (kind == 2);
    cmdSrEnter = (kind == 3);
    cmdSrExit  = (kind == 4);
    bankAddr = ba;
    addr     = a;
    @(negedge clk);
    cmdMrs = 0; cmdRead = 0; cmdOther = 0; cmdSrEnter = 0; cmdSrExit = 0;
    bankAddr = '0;
    addr     = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic errs(input string tag, input logic r, input logic t, input logic s);
    chk({tag, " errReserved"}, errReserved, r);
    chk({tag, " errTiming"}, errTiming, t);
    chk({tag, " errSequence"}, errSequence, s);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R6 reset state
    chk("R6 baseReg", baseReg, 0);
    chk("R6 extReg", extReg, 0);
    chk("R6 dllLocked", dllLocked, 0);
    errs("R6", 0, 0, 0);

    // R7 read at the first edge after reset is too early
    issue(1, 2'b00, 12'h0);
    errs("R7 early read", 0, 1, 0);
    idle(198);
    chk("R6 locked after 199 edges", dllLocked, 0);
    idle(1);
    chk("R6 locked after 200 edges", dllLocked, 1);
    issue(1, 2'b00, 12'h0);
    errs("R7 read after lock", 0, 0, 0);

    // R2 R3 sweep of base operating-mode field
    expBase = '0;
    for (int v = 0; v < 32; v++) begin
      logic [11:0] a;
      logic ok;
      a  = {v[4:0], 7'((v * 3) & 7'h7f)};
      ok = (v == 0) || (v == 2);
      issue(0, 2'b00, a);
      if (ok) expBase = a;
      chk($sformatf("R3 reserved flag mode=%0d", v), errReserved, !ok);
      chk($sformatf("R2 baseReg mode=%0d", v), baseReg, expBase);
      chk($sformatf("R11 seq mode=%0d", v), errSequence, 0);
      issue(0, 2'b00, 12'(v));
      expBase = 12'(v);
      chk($sformatf("R10 normal after mode=%0d", v), errSequence, 0);
      chk($sformatf("R2 normal write mode=%0d", v), baseReg, expBase);
    end

    // R1 bank selection
    issue(0, 2'b10, 12'h004);
    chk("R1 bank 10 reserved", errReserved, 1);
    issue(0, 2'b11, 12'h000);
    chk("R1 bank 11 reserved", errReserved, 1);
    chk("R1 base unchanged", baseReg, expBase);
    chk("R1 ext unchanged", extReg, 0);
    issue(0, 2'b01, 12'h004);
    expExt = 12'h004;
    chk("R1 ext written", extReg, expExt);
    chk("R1 base untouched by ext", baseReg, expBase);
    idle(2);

    // R4 sweep of extended fields
    for (int v = 0; v < 32; v++) begin
      logic [11:0] a;
      logic ok;
      a  = {v[4], 7'b0, v[3:0]};
      ok = !(v[4] || v[3] || v[1]);
      issue(0, 2'b01, a);
      if (ok) expExt = a;
      chk($sformatf("R4 reserved flag v=%0d", v), errReserved, !ok);
      chk($sformatf("R4 extReg v=%0d", v), extReg, expExt);
      idle(2);
    end

    // R5 write while a bank is active
    issue(0, 2'b01, 12'h001);
    expExt = 12'h001;
    idle(2);
    chk("R4 dll off drops lock", dllLocked, 0);
    issue(1, 2'b00, 12'h0);
    chk("R7 read with dll off", errTiming, 1);
    banksIdle = 1'b0;
    issue(0, 2'b01, 12'h000);
    banksIdle = 1'b1;
    errs("R5 busy banks", 0, 0, 1);
    chk("R5 ext unchanged", extReg, expExt);

    // R8 settling window after enabling by register write
    issue(0, 2'b01, 12'h000);
    expExt = 12'h000;
    chk("R8 ext enable", extReg, expExt);
    issue(2, 2'b00, 12'h0);
    chk("R8 non-read at E+1", errTiming, 1);
    issue(2, 2'b00, 12'h0);
    chk("R8 non-read at E+2", errTiming, 0);
    issue(1, 2'b00, 12'h0);
    chk("R7 read at E+3", errTiming, 1);
    idle(195);
    chk("R7 lock after E+198", dllLocked, 0);
    idle(1);
    chk("R7 lock after E+199", dllLocked, 1);
    issue(1, 2'b00, 12'h0);
    chk("R7 read at E+200", errTiming, 0);

    // R9 self refresh
    issue(3, 2'b00, 12'h0);
    chk("R9 sr entry drops lock", dllLocked, 0);
    issue(1, 2'b00, 12'h0);
    chk("R9 read in sr", errTiming, 1);
    issue(4, 2'b00, 12'h0);
    chk("R9 exit no flag", errTiming, 0);
    idle(8);
    issue(2, 2'b00, 12'h0);
    chk("R9 non-read at X+9", errTiming, 1);
    issue(2, 2'b00, 12'h0);
    chk("R9 non-read at X+10", errTiming, 0);
    idle(188);
    chk("R9 lock after X+198", dllLocked, 0);
    idle(1);
    chk("R9 lock after X+199", dllLocked, 1);

    // R10 DLL reset ordering
    issue(0, 2'b00, 12'h132);
    errs("R10 dll reset write", 0, 0, 0);
    chk("R2 dll reset stored", baseReg, 12'h132);
    issue(1, 2'b00, 12'h0);
    errs("R10 read after dll reset", 0, 0, 1);
    issue(0, 2'b00, 12'h132);
    issue(0, 2'b00, 12'h031);
    errs("R10 normal after dll reset", 0, 0, 0);
    chk("R10 baseReg", baseReg, 12'h031);
    issue(0, 2'b00, 12'h132);
    issue(0, 2'b00, 12'h200);
    errs("R10 reserved after dll reset", 1, 0, 1);
    chk("R3 baseReg kept", baseReg, 12'h132);

    // R11 pulses last one cycle
    idle(1);
    errs("R11 pulse cleared", 0, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule